// File: doc/BRIEF.md
# Two-Level 32-bit Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level table of 32-bit entries in memory. It first reads a directory entry selected by the top ten address bits. It then either reads a table entry selected by the next ten bits, or stops at the directory with a 4 MB page when large pages are enabled. A large-page entry may carry eight extra physical address bits, so the result is 40 bits wide. The walker keeps the accessed and dirty bits of the entries up to date through compare-and-write transactions. When such a write finds the entry changed under it, the walker re-reads the entry and tries again.

A requester presents one address at a time with a store flag, the paging and large-page enables, and the table root. The walker answers with a single-cycle response. The response carries the physical address, the page size, the combined user and writable attributes and an execute grant, or a fault code. When paging is off, the walker returns the address unchanged with full rights and makes no memory access. Permission checking and result caching are left to the surrounding logic.

Top module: `pt32_walker`

## Requirements
- R1: The directory entry is read from address {root_base[31:12], va[31:22], 2'b00}.
- R2: For a 4 KB walk, the table entry is read from {dir[31:12], va[21:12], 2'b00}. The physical address is {8'h00, tbl[31:12], va[11:0]} and rsp_big is 0.
- R3: An entry with bit 0 (present) clear, at either level, ends the walk with rsp_fault = 1. In that case rsp_paddr, rsp_big, rsp_user, rsp_writable and rsp_exec are all 0, and no write is issued.
- R4: A directory entry with bit 7 set, read while big_page_en was 1 at request time, ends the walk as a 4 MB page. The physical address is {dir[20:13], dir[31:22], va[21:0]} and rsp_big is 1. With big_page_en at 0, bit 7 is ignored and the entry points to a table.
- R5: For a 4 MB page whose directory entry has bit 21 set, the result is rsp_fault = 2 and no write is issued.
- R6: In a 4 KB walk, a directory entry with bit 5 (accessed) clear is updated with a compare-and-write that sets bit 5. If the entry already has bit 5 set, no write is issued. A failed compare makes the walker re-read the directory entry.
- R7: rsp_user is the AND of bit 2 of every entry read on the final pass, and rsp_writable starts from the AND of bit 1 of those entries. rsp_exec is 1 on every successful response.
- R8: The leaf entry gets bit 5 set on every access and bit 6 (dirty) set as well on a store. A write is issued only when one of these bits is still clear. rsp_writable is further cleared on a load when the leaf's bit 6 is clear.
- R9: A failed compare-and-write on the leaf restarts the walk from the directory read.
- R10: With paging_en low, the response comes one cycle after acceptance with rsp_paddr = {8'h00, va}, all three rights set, rsp_big = 0, no fault and no memory access.
- R11: req_ready is high only while idle, rsp_valid is a one-cycle pulse, and a memory request holds its address until mem_ack.
- R12: A compare-and-write puts the value read into mem_cmp and that value with the new bits ORed in onto mem_wdata. The memory stores it only if the location still equals mem_cmp, and reports the outcome on mem_cas_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled on acceptance |
| big_page_en | input | 1 | 4 MB page enable, sampled on acceptance |
| root_base | input | 32 | Directory base, bits 31:12 used |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | Access is a store |
| mem_req | output | 1 | Memory transaction pending |
| mem_wr | output | 1 | Transaction is a compare-and-write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | New entry value |
| mem_cmp | output | 32 | Expected current entry value |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | 32 | Entry read data |
| mem_cas_ok | input | 1 | Compare matched and the write was done |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 40 | Physical address |
| rsp_big | output | 1 | Result is a 4 MB page |
| rsp_user | output | 1 | Combined user attribute |
| rsp_writable | output | 1 | Combined writable attribute |
| rsp_exec | output | 1 | Execute granted |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 reserved bit |

## Verification
The bench builds the walker with the default WIDE_PA = 1. This brings the upper physical address bits of a large page and the reserved-bit fault on entry bit 21 within reach of the checks. A memory model in the bench can corrupt an entry just before the next compare-and-write. This forces both the directory retry and the full-walk restart, and the bench counts the reads and writes seen on the memory port to confirm the extra passes. Entries are laid out so that the same large-page directory entry is walked both as a 4 MB page and, with large pages disabled, as a table pointer.

// File: rtl/pt32_walker.sv
module pt32_walker #(
  parameter bit WIDE_PA = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        paging_en,
  input  logic        big_page_en,
  input  logic [31:0] root_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_store,
  output logic        mem_req,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [31:0] mem_cmp,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_cas_ok,
  output logic        rsp_valid,
  output logic [39:0] rsp_paddr,
  output logic        rsp_big,
  output logic        rsp_user,
  output logic        rsp_writable,
  output logic        rsp_exec,
  output logic [1:0]  rsp_fault
);

  localparam int EW     = 32;
  localparam int PA_W   = 40;
  localparam int HI_W   = PA_W - EW;
  localparam int B_P    = 0;
  localparam int B_RW   = 1;
  localparam int B_US   = 2;
  localparam int B_ACC  = 5;
  localparam int B_DIRT = 6;
  localparam int B_BIG  = 7;
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_NP   = 2'd1;
  localparam logic [1:0] F_RSV  = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_DSET, S_TBL, S_LEAF, S_RESP} st_t;

  st_t st;
  logic [31:0] va, root, pde, leaf;
  logic        store, bp_on, leaf_big, us_r, rw_r;

  logic [31:0] dir_addr, tbl_addr, leaf_set;
  logic        leaf_need, rd_rsv;
  logic [HI_W-1:0] leaf_hi;

  generate
    if (WIDE_PA) begin : g_wide
      assign leaf_hi = leaf[20:13];
      assign rd_rsv  = mem_rdata[21];
    end else begin : g_narrow
      assign leaf_hi = '0;
      assign rd_rsv  = 1'b0;
    end
  endgenerate

  assign dir_addr  = {root[31:12], va[31:22], 2'b00};
  assign tbl_addr  = {pde[31:12], va[21:12], 2'b00};
  assign leaf_set  = (32'd1 << B_ACC) | (store ? (32'd1 << B_DIRT) : 32'd0);
  assign leaf_need = |(leaf_set & ~leaf);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign mem_req   = (st == S_DIR) || (st == S_DSET) || (st == S_TBL) ||
                     ((st == S_LEAF) && leaf_need);
  assign mem_wr    = (st == S_DSET) || (st == S_LEAF);

  always_comb begin
    mem_addr  = dir_addr;
    mem_cmp   = '0;
    mem_wdata = '0;
    case (st)
      S_DSET: begin
        mem_cmp   = pde;
        mem_wdata = pde | (32'd1 << B_ACC);
      end
      S_TBL:  mem_addr = tbl_addr;
      S_LEAF: begin
        mem_addr  = leaf_big ? dir_addr : tbl_addr;
        mem_cmp   = leaf;
        mem_wdata = leaf | leaf_set;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va <= '0; root <= '0; pde <= '0; leaf <= '0;
      store <= 1'b0; bp_on <= 1'b0; leaf_big <= 1'b0;
      us_r <= 1'b0; rw_r <= 1'b0;
      rsp_paddr <= '0; rsp_big <= 1'b0; rsp_user <= 1'b0;
      rsp_writable <= 1'b0; rsp_exec <= 1'b0; rsp_fault <= F_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va    <= req_vaddr;
          store <= req_store;
          root  <= root_base;
          bp_on <= big_page_en;
          if (!paging_en) begin
            rsp_paddr    <= {{HI_W{1'b0}}, req_vaddr};
            rsp_big      <= 1'b0;
            rsp_user     <= 1'b1;
            rsp_writable <= 1'b1;
            rsp_exec     <= 1'b1;
            rsp_fault    <= F_NONE;
            st           <= S_RESP;
          end else begin
            st <= S_DIR;
          end
        end
        S_DIR: if (mem_ack) begin
          pde  <= mem_rdata;
          us_r <= mem_rdata[B_US];
          rw_r <= mem_rdata[B_RW];
          if (!mem_rdata[B_P]) begin
            rsp_paddr <= '0; rsp_big <= 1'b0; rsp_user <= 1'b0;
            rsp_writable <= 1'b0; rsp_exec <= 1'b0; rsp_fault <= F_NP;
            st <= S_RESP;
          end else if (mem_rdata[B_BIG] && bp_on) begin
            if (rd_rsv) begin
              rsp_paddr <= '0; rsp_big <= 1'b0; rsp_user <= 1'b0;
              rsp_writable <= 1'b0; rsp_exec <= 1'b0; rsp_fault <= F_RSV;
              st <= S_RESP;
            end else begin
              leaf     <= mem_rdata;
              leaf_big <= 1'b1;
              st       <= S_LEAF;
            end
          end else begin
            st <= mem_rdata[B_ACC] ? S_TBL : S_DSET;
          end
        end
        S_DSET: if (mem_ack) st <= mem_cas_ok ? S_TBL : S_DIR;
        S_TBL: if (mem_ack) begin
          if (!mem_rdata[B_P]) begin
            rsp_paddr <= '0; rsp_big <= 1'b0; rsp_user <= 1'b0;
            rsp_writable <= 1'b0; rsp_exec <= 1'b0; rsp_fault <= F_NP;
            st <= S_RESP;
          end else begin
            leaf     <= mem_rdata;
            leaf_big <= 1'b0;
            us_r     <= us_r & mem_rdata[B_US];
            rw_r     <= rw_r & mem_rdata[B_RW];
            st       <= S_LEAF;
          end
        end
        S_LEAF: if (!leaf_need || mem_ack) begin
          if (leaf_need && !mem_cas_ok) begin
            st <= S_DIR;
          end else begin
            rsp_paddr    <= leaf_big ? {leaf_hi, leaf[31:22], va[21:0]}
                                     : {{HI_W{1'b0}}, leaf[31:12], va[11:0]};
            rsp_big      <= leaf_big;
            rsp_user     <= us_r;
            rsp_writable <= rw_r & (store | leaf[B_DIRT]);
            rsp_exec     <= 1'b1;
            rsp_fault    <= F_NONE;
            st           <= S_RESP;
          end
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr))); // R11

  AST_CAS_ORSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wr) |-> (((mem_wdata & ~mem_cmp) != 32'd0) &&
                             ((mem_cmp & ~mem_wdata) == 32'd0))); // R12

  AST_ID_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !paging_en) |=>
      (rsp_valid && rsp_paddr == {8'h00, $past(req_vaddr)} && rsp_fault == 2'd0 &&
       rsp_user && rsp_writable && rsp_exec)); // R10

  AST_OK_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> rsp_exec); // R7

endmodule

// File: tb/pt32_walker_tb.sv
module pt32_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        paging_en = 1'b0, big_page_en = 1'b0;
  logic [31:0] root_base = 32'h0001_0000;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_cmp;
  logic        mem_ack = 1'b0, mem_cas_ok = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_big, rsp_user, rsp_writable, rsp_exec;
  logic [39:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  pt32_walker dut_i (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .big_page_en(big_page_en),
    .root_base(root_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store), .mem_req(mem_req), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_cmp(mem_cmp), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_cas_ok(mem_cas_ok), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_big(rsp_big), .rsp_user(rsp_user),
    .rsp_writable(rsp_writable), .rsp_exec(rsp_exec), .rsp_fault(rsp_fault)
  );

  typedef struct packed {
    logic [39:0] pa;
    logic big, u, w, x;
    logic [1:0] f;
  } res_t;

  int total = 0, fails = 0;
  int rcnt = 0, wcnt = 0, interfere = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rlog [$];
  res_t  exq [$];
  string tagq [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin : memory_model
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!mem_wr) begin
          mem_rdata = rd(mem_addr);
          rlog.push_back(mem_addr);
          rcnt++;
        end else begin
          if (interfere > 0) begin
            mem[mem_addr] = rd(mem_addr) | 32'h200;
            interfere--;
          end
          mem_cas_ok = (rd(mem_addr) == mem_cmp);
          if (mem_cas_ok) mem[mem_addr] = mem_wdata;
          wcnt++;
        end
        mem_ack = 1'b1;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        res_t act, exp;
        string tg;
        act = '{rsp_paddr, rsp_big, rsp_user, rsp_writable, rsp_exec, rsp_fault};
        if (exq.size() == 0) begin
          chk(1'b0, "R11 unexpected response", 64'(act), 64'h0);
        end else begin
          exp = exq.pop_front();
          tg  = tagq.pop_front();
          chk(act == exp, tg, 64'(act), 64'(exp));
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic st, input logic pg, input logic bp,
                      input res_t exp, input string tag);
    rcnt = 0; wcnt = 0; rlog.delete();
    exq.push_back(exp);
    tagq.push_back(tag);
    @(negedge clk);
    req_vaddr = va; req_store = st; paging_en = pg; big_page_en = bp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11 pulse ends and walker idles", {62'h0, rsp_valid, req_ready}, 64'h1);
  endtask

  localparam res_t NPF = '{40'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1};

  initial begin : stimulus
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "reset state R11",
        {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1'b1;

    // R10 identity map
    walk(32'hDEAD_B000, 1'b1, 1'b0, 1'b1, '{40'h00_DEAD_B000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0}, "R10 identity");
    chk(rcnt + wcnt == 0, "R10 no memory access", 64'(rcnt + wcnt), 64'h0);

    // 4 KB walk, load, directory accessed clear
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_000C] = 32'h1234_5003;
    walk(32'h0040_3123, 1'b0, 1'b1, 1'b1, '{40'h00_1234_5123, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0}, "R2 R7 R8 4KB load");
    chk(rlog.size() == 2 && rlog[0] == 32'h0001_0004, "R1 directory address",
        64'(rlog.size() > 0 ? rlog[0] : 0), 64'h1_0004);
    chk(rlog.size() == 2 && rlog[1] == 32'h0002_000C, "R2 table address",
        64'(rlog.size() > 1 ? rlog[1] : 0), 64'h2_000C);
    chk(rd(32'h0001_0004) == 32'h0002_0027, "R6 directory accessed set", 64'(rd(32'h0001_0004)), 64'h2_0027);
    chk(rd(32'h0002_000C) == 32'h1234_5023, "R8 leaf accessed set", 64'(rd(32'h0002_000C)), 64'h1234_5023);

    // store: directory already accessed, leaf gets dirty
    walk(32'h0040_3123, 1'b1, 1'b1, 1'b1, '{40'h00_1234_5123, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0}, "R8 4KB store");
    chk(wcnt == 1, "R6 no directory write when accessed", 64'(wcnt), 64'h1);
    chk(rd(32'h0002_000C) == 32'h1234_5063, "R8 leaf dirty set", 64'(rd(32'h0002_000C)), 64'h1234_5063);

    // load on dirty leaf: writable, no writes
    walk(32'h0040_3123, 1'b0, 1'b1, 1'b1, '{40'h00_1234_5123, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0}, "R8 load dirty leaf");
    chk(wcnt == 0, "R8 no write when bits set", 64'(wcnt), 64'h0);

    // not present directory / table
    walk(32'h0080_0000, 1'b0, 1'b1, 1'b1, NPF, "R3 directory not present");
    mem[32'h0001_000C] = 32'h0003_0021;
    walk(32'h00C0_0000, 1'b1, 1'b1, 1'b1, NPF, "R3 table not present");
    chk(wcnt == 0, "R3 no write on fault", 64'(wcnt), 64'h0);

    // 4 MB page with high address bits
    mem[32'h0001_0014] = 32'h0ACB_4087;
    walk(32'h0147_89AB, 1'b0, 1'b1, 1'b1, '{40'h5A_0AC7_89AB, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0}, "R4 4MB page");
    chk(rcnt == 1 && rd(32'h0001_0014) == 32'h0ACB_40A7, "R8 4MB leaf accessed",
        64'(rd(32'h0001_0014)), 64'h0ACB_40A7);

    // same entry with large pages disabled walks a table
    mem[32'h0ACB_41E0] = 32'h0055_5067;
    walk(32'h0147_89AB, 1'b0, 1'b1, 1'b0, '{40'h00_0055_59AB, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0}, "R4 size bit ignored");
    chk(rlog.size() == 2 && rlog[1] == 32'h0ACB_41E0, "R4 table address when disabled",
        64'(rlog.size() > 1 ? rlog[1] : 0), 64'h0ACB_41E0);

    // reserved bit 21
    mem[32'h0001_0018] = 32'h0020_0081;
    walk(32'h0180_0000, 1'b1, 1'b1, 1'b1, '{40'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2}, "R5 reserved fault");
    chk(wcnt == 0, "R5 no write", 64'(wcnt), 64'h0);

    // directory compare-and-write fails once
    mem[32'h0001_001C] = 32'h0004_0003;
    mem[32'h0004_0004] = 32'h0777_7067;
    interfere = 1;
    walk(32'h01C0_1000, 1'b0, 1'b1, 1'b1, '{40'h00_0777_7000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0}, "R6 directory retry");
    chk(rcnt == 3 && wcnt == 2, "R6 directory re-read", 64'(rcnt * 16 + wcnt), 64'h32);
    chk(rd(32'h0001_001C) == 32'h0004_0223, "R12 retry keeps foreign bit", 64'(rd(32'h0001_001C)), 64'h4_0223);

    // leaf compare-and-write fails once
    mem[32'h0001_0020] = 32'h0005_0027;
    mem[32'h0005_0008] = 32'h0666_6005;
    interfere = 1;
    walk(32'h0200_2ABC, 1'b1, 1'b1, 1'b1, '{40'h00_0666_6ABC, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0}, "R9 leaf restart");
    chk(rcnt == 4 && wcnt == 2, "R9 full walk restarted", 64'(rcnt * 16 + wcnt), 64'h42);
    chk(rd(32'h0005_0008) == 32'h0666_6265, "R9 leaf final value", 64'(rd(32'h0005_0008)), 64'h0666_6265);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule